// File: doc/BRIEF.md
# Branch Target Buffer with Instruction Folding

This block predicts control flow during instruction fetch. Every cycle the address being fetched is compared against a small fully associative table of recently resolved branches. This happens before anything is known about the instruction at that address. On a match the block returns the remembered target and a one-bit record of whether the branch went that way the last time it ran. From these it computes the address the fetch unit should use next.

Each entry also keeps a copy of the instruction located at the branch target. For an unconditional branch predicted taken, with folding enabled, the block hands that target instruction straight to decode and steers fetch to the word after the target. The branch itself then drops out of the stream, and the bubble that normally follows it is removed as well.

The execute stage reports every branch it resolves: its address, its direction, its target, the instruction at that target and whether it is unconditional. The block compares the report with its own table and raises a mispredict flag when the earlier prediction was wrong. It then inserts the branch, or corrects the entry. Flushing the pipeline is left to the surrounding logic.

Top module: `btb_fold`

## Requirements
- R1: After reset deassertion, and while reset is held, no entry is valid: every lookup reports hit_o = 0 until a branch has been resolved.
- R2: On a lookup miss, pred_taken_o = 0, fold_valid_o = 0 and next_pc_o = fetch_pc_i + 4 (INSN_W/8 bytes).
- R3: On a hit whose history bit is 1, with no folding applied, pred_taken_o = 1 and next_pc_o equals the stored target.
- R4: On a hit whose history bit is 0, hit_o = 1, pred_taken_o = 0 and next_pc_o = fetch_pc_i + 4.
- R5: A resolved branch whose address is not in the table is inserted. It takes its full address as tag, its direction as history bit, and its target, target instruction and unconditional flag. A lookup of that address in the next cycle hits.
- R6: mispredict_o is 1 exactly during a resolve cycle in one of three cases: the branch missed and was taken; it hit and its history bit differs from the actual direction; or it hit with history 1, was taken, and the stored target differs from the actual target.
- R7: On a mispredicted hit the entry's history bit is set to the actual direction. If the branch was taken, its target, target instruction and unconditional flag are replaced as well. The next lookup reflects the new values.
- R8: When fold_en_i = 1 and a hit predicts taken for an entry marked unconditional, fold_valid_o = 1, fold_insn_o is the stored target instruction and next_pc_o = target + 4. A conditional entry, or fold_en_i = 0, gives fold_valid_o = 0.
- R9: Insertions go to slots in round-robin order starting at slot 0. With 8 entries, the ninth insertion evicts the branch inserted first and the tenth evicts the second.
- R10: When a resolve and a lookup of the same address fall in one cycle, that cycle's lookup returns the table contents from before the write. The write is seen from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | PC_W | Address being fetched this cycle |
| fold_en_i | input | 1 | Allow unconditional taken hits to supply their target instruction |
| hit_o | output | 1 | Fetch address found in the table |
| pred_taken_o | output | 1 | Predicted taken |
| next_pc_o | output | PC_W | Next fetch address |
| fold_valid_o | output | 1 | fold_insn_o carries the target instruction for decode |
| fold_insn_o | output | INSN_W | Folded target instruction (zero when not folding) |
| res_valid_i | input | 1 | A branch is being resolved this cycle |
| res_pc_i | input | PC_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_uncond_i | input | 1 | Resolved branch is unconditional |
| res_target_i | input | PC_W | Actual target address |
| res_target_insn_i | input | INSN_W | Instruction found at the actual target |
| mispredict_o | output | 1 | The table's prediction for the resolved branch was wrong |

## Verification
Eviction is the hardest situation to reach from the ports. The table must first be filled with eight distinct branches, and only the next two insertions show whether the oldest entries are the ones replaced. After the table-driven phase has placed three branches, the stimulus inserts six more, so the ninth insertion overwrites slot 0. A tenth insertion overwrites slot 1. Lookups then show which addresses survived. Same-cycle resolve and lookup of one address is placed directly in the vector table: a changed target is reported while the same address is fetched, and the old prediction must still be visible in that cycle.

// File: rtl/btb_fold_pkg.sv
package btb_fold_pkg;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_INSN_W  = 32;
  localparam int unsigned DEF_ENTRIES = 8;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_ALLOC = 2'd1,
    UPD_FIX   = 2'd2
  } upd_e;
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    valid_i,
  input  logic [PC_W-1:0] tags_i [N],
  input  logic [PC_W-1:0] pc_i,
  output logic            hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == pc_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned N      = 8,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  btb_fold_pkg::upd_e upd_i,
  input  logic [IDX_W-1:0]  fix_idx_i,
  input  logic [PC_W-1:0]   tag_i,
  input  logic              taken_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              unc_i,
  output logic [N-1:0]      valid_o,
  output logic [PC_W-1:0]   tag_o  [N],
  output logic [N-1:0]      hist_o,
  output logic [PC_W-1:0]   tgt_o  [N],
  output logic [INSN_W-1:0] insn_o [N],
  output logic [N-1:0]      unc_o
);
  import btb_fold_pkg::*;

  logic [IDX_W-1:0] ptr_q;

  // round-robin victim pointer, advances only on insertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (upd_i == UPD_ALLOC) begin
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic              v_q;
    logic [PC_W-1:0]   tag_q;
    logic              hist_q;
    logic [PC_W-1:0]   tgt_q;
    logic [INSN_W-1:0] insn_q;
    logic              unc_q;
    logic              sel_alloc;
    logic              sel_fix;

    assign sel_alloc = (upd_i == UPD_ALLOC) && (ptr_q == IDX_W'(g));
    assign sel_fix   = (upd_i == UPD_FIX) && (fix_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q    <= 1'b0;
        tag_q  <= '0;
        hist_q <= 1'b0;
        tgt_q  <= '0;
        insn_q <= '0;
        unc_q  <= 1'b0;
      end else if (sel_alloc) begin
        v_q    <= 1'b1;
        tag_q  <= tag_i;
        hist_q <= taken_i;
        tgt_q  <= tgt_i;
        insn_q <= insn_i;
        unc_q  <= unc_i;
      end else if (sel_fix) begin
        hist_q <= taken_i;
        if (taken_i) begin
          tgt_q  <= tgt_i;
          insn_q <= insn_i;
          unc_q  <= unc_i;
        end
      end
    end

    assign valid_o[g] = v_q;
    assign tag_o[g]   = tag_q;
    assign hist_o[g]  = hist_q;
    assign tgt_o[g]   = tgt_q;
    assign insn_o[g]  = insn_q;
    assign unc_o[g]   = unc_q;
  end
endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_W     = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic              hit_i,
  input  logic              hist_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              unc_i,
  input  logic              fold_en_i,
  output logic              pred_taken_o,
  output logic              fold_valid_o,
  output logic [INSN_W-1:0] fold_insn_o,
  output logic [PC_W-1:0]   next_pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_comb begin
    pred_taken_o = hit_i && hist_i;
    fold_valid_o = pred_taken_o && unc_i && fold_en_i;
    fold_insn_o  = fold_valid_o ? insn_i : '0;
    if (fold_valid_o)      next_pc_o = tgt_i + STEP; // target already delivered
    else if (pred_taken_o) next_pc_o = tgt_i;
    else                   next_pc_o = pc_i + STEP;
  end
endmodule

// File: rtl/btb_fold.sv
module btb_fold #(
  parameter int unsigned PC_W    = btb_fold_pkg::DEF_PC_W,
  parameter int unsigned INSN_W  = btb_fold_pkg::DEF_INSN_W,
  parameter int unsigned ENTRIES = btb_fold_pkg::DEF_ENTRIES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic              fold_en_i,
  output logic              hit_o,
  output logic              pred_taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              fold_valid_o,
  output logic [INSN_W-1:0] fold_insn_o,
  input  logic              res_valid_i,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic              res_taken_i,
  input  logic              res_uncond_i,
  input  logic [PC_W-1:0]   res_target_i,
  input  logic [INSN_W-1:0] res_target_insn_i,
  output logic              mispredict_o
);
  import btb_fold_pkg::*;

  localparam int unsigned IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned INSN_BYTES = INSN_W / 8;

  logic [ENTRIES-1:0] ent_valid;
  logic [PC_W-1:0]    ent_tag  [ENTRIES];
  logic [ENTRIES-1:0] ent_hist;
  logic [PC_W-1:0]    ent_tgt  [ENTRIES];
  logic [INSN_W-1:0]  ent_insn [ENTRIES];
  logic [ENTRIES-1:0] ent_unc;

  logic             f_hit, r_hit;
  logic [IDX_W-1:0] f_idx, r_idx;
  logic             r_wrong;
  upd_e             upd;

  btb_match #(.N(ENTRIES), .PC_W(PC_W)) i_fetch_match (
    .valid_i (ent_valid),
    .tags_i  (ent_tag),
    .pc_i    (fetch_pc_i),
    .hit_o   (f_hit),
    .idx_o   (f_idx)
  );

  btb_match #(.N(ENTRIES), .PC_W(PC_W)) i_res_match (
    .valid_i (ent_valid),
    .tags_i  (ent_tag),
    .pc_i    (res_pc_i),
    .hit_o   (r_hit),
    .idx_o   (r_idx)
  );

  btb_next_pc #(.PC_W(PC_W), .INSN_W(INSN_W), .INSN_BYTES(INSN_BYTES)) i_next_pc (
    .pc_i         (fetch_pc_i),
    .hit_i        (f_hit),
    .hist_i       (ent_hist[f_idx]),
    .tgt_i        (ent_tgt[f_idx]),
    .insn_i       (ent_insn[f_idx]),
    .unc_i        (ent_unc[f_idx]),
    .fold_en_i    (fold_en_i),
    .pred_taken_o (pred_taken_o),
    .fold_valid_o (fold_valid_o),
    .fold_insn_o  (fold_insn_o),
    .next_pc_o    (next_pc_o)
  );

  // compare the resolved outcome with what the table would have predicted
  always_comb begin
    if (r_hit) begin
      r_wrong = (ent_hist[r_idx] != res_taken_i) ||
                (res_taken_i && (ent_tgt[r_idx] != res_target_i));
    end else begin
      r_wrong = res_taken_i;
    end
    mispredict_o = res_valid_i && r_wrong;

    upd = UPD_NONE;
    if (res_valid_i && !r_hit)      upd = UPD_ALLOC;
    else if (res_valid_i && r_wrong) upd = UPD_FIX;
  end

  btb_store #(.N(ENTRIES), .PC_W(PC_W), .INSN_W(INSN_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .fix_idx_i (r_idx),
    .tag_i     (res_pc_i),
    .taken_i   (res_taken_i),
    .tgt_i     (res_target_i),
    .insn_i    (res_target_insn_i),
    .unc_i     (res_uncond_i),
    .valid_o   (ent_valid),
    .tag_o     (ent_tag),
    .hist_o    (ent_hist),
    .tgt_o     (ent_tgt),
    .insn_o    (ent_insn),
    .unc_o     (ent_unc)
  );

  assign hit_o = f_hit;
endmodule

// File: rtl/btb_fold_chk.sv
module btb_fold_chk #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned STEP = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            fold_en_i,
  input logic            hit_o,
  input logic            pred_taken_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            fold_valid_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i,
  input logic [PC_W-1:0] res_target_i,
  input logic            mispredict_o
);
  logic past_ok, seen_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok  <= 1'b0;
      seen_res <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (res_valid_i) seen_res <= 1'b1;
    end
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> seen_res);

  assert_miss_sequential_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!pred_taken_o && !fold_valid_o && next_pc_o == fetch_pc_i + PC_W'(STEP)));

  assert_not_taken_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pred_taken_o) |-> (next_pc_o == fetch_pc_i + PC_W'(STEP)));

  assert_insert_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(res_valid_i) && fetch_pc_i == $past(res_pc_i)) |-> hit_o);

  assert_flag_only_on_resolve_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> res_valid_i);

  assert_taken_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(res_valid_i && res_taken_i) && fetch_pc_i == $past(res_pc_i) && !fold_valid_o)
      |-> (pred_taken_o && next_pc_o == $past(res_target_i)));

  assert_fold_needs_taken_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_valid_o |-> (hit_o && pred_taken_o && fold_en_i));
endmodule

bind btb_fold btb_fold_chk #(.PC_W(PC_W), .STEP(INSN_W / 8)) i_btb_fold_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_pc_i   (fetch_pc_i),
  .fold_en_i    (fold_en_i),
  .hit_o        (hit_o),
  .pred_taken_o (pred_taken_o),
  .next_pc_o    (next_pc_o),
  .fold_valid_o (fold_valid_o),
  .res_valid_i  (res_valid_i),
  .res_pc_i     (res_pc_i),
  .res_taken_i  (res_taken_i),
  .res_target_i (res_target_i),
  .mispredict_o (mispredict_o)
);

// File: tb/test_btb_fold.sv
module test_btb_fold;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fold_en = 1'b0;
  logic        hit, pred_taken, fold_valid, misp;
  logic [31:0] next_pc, fold_insn;
  logic        res_valid = 1'b0, res_taken = 1'b0, res_uncond = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0, res_insn = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  btb_fold i_btb_fold (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc), .fold_en_i(fold_en),
    .hit_o(hit), .pred_taken_o(pred_taken), .next_pc_o(next_pc),
    .fold_valid_o(fold_valid), .fold_insn_o(fold_insn),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_uncond_i(res_uncond), .res_target_i(res_target),
    .res_target_insn_i(res_insn), .mispredict_o(misp)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rt;
    logic [31:0] rtgt;
    logic        ru;
    logic [31:0] rinsn;
    logic        fe;
    logic [31:0] fpc;
    logic        eh;
    logic        et;
    logic [31:0] en;
    logic        ef;
    logic [31:0] ei;
    logic        em;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h100, 1'b1, 32'h200, 1'b0, 32'hAAAA0001, 1'b0, 32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0,        1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h0,        1'b0},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b1, 32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h100, 1'b0, 32'h200, 1'b0, 32'h0,        1'b0, 32'h300, 1'b0, 1'b0, 32'h304, 1'b0, 32'h0,        1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h100, 1'b0, 32'h200, 1'b0, 32'h0,        1'b0, 32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h400, 1'b1, 32'h500, 1'b1, 32'hBBBB0002, 1'b0, 32'h400, 1'b0, 1'b0, 32'h404, 1'b0, 32'h0,        1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b1, 32'h400, 1'b1, 1'b1, 32'h504, 1'b1, 32'hBBBB0002, 1'b0},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 32'h400, 1'b1, 1'b1, 32'h500, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h400, 1'b1, 32'h600, 1'b1, 32'hCCCC0003, 1'b1, 32'h400, 1'b1, 1'b1, 32'h504, 1'b1, 32'hBBBB0002, 1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b1, 32'h400, 1'b1, 1'b1, 32'h604, 1'b1, 32'hCCCC0003, 1'b0},
    '{1'b1, 32'h400, 1'b1, 32'h600, 1'b1, 32'hCCCC0003, 1'b0, 32'h700, 1'b0, 1'b0, 32'h704, 1'b0, 32'h0,        1'b0},
    '{1'b1, 32'h800, 1'b0, 32'h900, 1'b0, 32'h0,        1'b0, 32'h800, 1'b0, 1'b0, 32'h804, 1'b0, 32'h0,        1'b0},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 32'h800, 1'b1, 1'b0, 32'h804, 1'b0, 32'h0,        1'b0}
  };

  function automatic string row_req(int i);
    case (i)
      0:       return "R1";
      1:       return "R10/R2/R6";
      2:       return "R3/R5";
      3:       return "R8";
      4:       return "R6/R2";
      5:       return "R4/R7";
      6:       return "R6/R4";
      7:       return "R5/R6";
      8:       return "R8";
      9:       return "R8/R3";
      10:      return "R10/R6";
      11:      return "R7/R8";
      12:      return "R6";
      13:      return "R10/R5";
      default: return "R5/R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [31:0] rpc, input logic rt,
                       input logic [31:0] rtgt, input logic ru, input logic [31:0] rinsn,
                       input logic fe, input logic [31:0] fpc);
    @(negedge clk);
    res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtgt;
    res_uncond = ru; res_insn = rinsn; fold_en = fe; fetch_pc = fpc;
    #2;
  endtask

  task automatic look(input logic [31:0] fpc);
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, fpc);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "hit during reset", {31'b0, hit}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rv, VECS[i].rpc, VECS[i].rt, VECS[i].rtgt, VECS[i].ru,
            VECS[i].rinsn, VECS[i].fe, VECS[i].fpc);
      chk(row_req(i), "hit", {31'b0, hit}, {31'b0, VECS[i].eh});
      chk(row_req(i), "pred_taken", {31'b0, pred_taken}, {31'b0, VECS[i].et});
      chk(row_req(i), "next_pc", next_pc, VECS[i].en);
      chk(row_req(i), "fold_valid", {31'b0, fold_valid}, {31'b0, VECS[i].ef});
      if (VECS[i].ef) chk(row_req(i), "fold_insn", fold_insn, VECS[i].ei);
      chk(row_req(i), "mispredict", {31'b0, misp}, {31'b0, VECS[i].em});
    end

    // R9: slots 0..2 hold 0x100, 0x400, 0x800; fill 3..7, then wrap
    for (int k = 0; k < 6; k++) begin
      logic [31:0] pc;
      pc = (k < 5) ? 32'h1000 + 32'(k) * 32'h100 : 32'h2000;
      drive(1'b1, pc, 1'b1, 32'h3000, 1'b0, 32'h0, 1'b0, 32'h10);
      chk("R6", "mispredict on taken miss", {31'b0, misp}, 32'h1);
    end
    look(32'h100);
    chk("R9", "oldest evicted", {31'b0, hit}, 32'h0);
    look(32'h400);
    chk("R9", "second kept", {31'b0, hit}, 32'h1);
    look(32'h2000);
    chk("R9", "ninth present", {31'b0, hit}, 32'h1);
    chk("R3", "ninth target", next_pc, 32'h3000);
    drive(1'b1, 32'h2100, 1'b1, 32'h3100, 1'b0, 32'h0, 1'b0, 32'h10);
    look(32'h400);
    chk("R9", "tenth evicts second", {31'b0, hit}, 32'h0);
    look(32'h800);
    chk("R9", "third kept", {31'b0, hit}, 32'h1);

    // R1: asynchronous reset clears the table
    @(negedge clk);
    fetch_pc = 32'h800;
    rst_ni = 1'b0;
    #1;
    chk("R1", "hit in reset", {31'b0, hit}, 32'h0);
    chk("R2", "next_pc in reset", next_pc, 32'h804);
    @(negedge clk);
    rst_ni = 1'b1;
    look(32'h2000);
    chk("R1", "hit after reset", {31'b0, hit}, 32'h0);
    chk("R2", "next_pc after reset", next_pc, 32'h2004);

    finish_run();
  end
endmodule